// File: doc/BRIEF.md
# Conditional Branch Evaluation Unit

This block resolves one jump-class instruction per cycle. It takes the 8-bit opcode, the two 64-bit register operands, the 32-bit immediate, the signed 16-bit word offset and the current program counter. One clock later it reports whether the branch is taken and gives the program counter of the next instruction. It also raises one of three side flags: a function call, a program return, or an encoding that this unit rejects. The program counter counts 64-bit instruction slots, so the fall-through address is always the current one plus one.

The opcode is split into three fields. The top nibble (bits 7:4) holds the condition code. Bit 3 selects the second operand: 1 means the source register, 0 means the immediate. The low three bits hold the class: 5 is the 64-bit jump class and 6 is the 32-bit jump class. The same compare matrix serves both classes. It covers equality, unsigned order, signed order and a bit test. A pipeline places the unit after operand read and uses its outputs to steer fetch. Carrying out the call or return itself belongs to other logic.

Top module: `branch_resolve`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid`, `out_taken`, `out_call`, `out_exit` and `out_illegal` are 0 after that edge.
- R2: The outputs for an instruction presented with `in_valid` high appear exactly one clock edge later, together with `out_valid` = 1. When `in_valid` is low, the next cycle shows `out_valid` and all four flags at 0.
- R3: If opcode bit 3 is 1, the second operand is `src_val`. If it is 0, the second operand is `imm`, sign-extended to 64 bits for class 5 and taken as its 32 bits for class 6.
- R4: Codes 0x1 (equal), 0x5 (not equal) and 0x4 (taken when the AND of the operands is nonzero) set `out_taken` according to their relation.
- R5: Codes 0x2 (>), 0x3 (>=), 0xa (<) and 0xb (<=) compare the operands as unsigned numbers.
- R6: Codes 0x6 (>), 0x7 (>=), 0xc (<) and 0xd (<=) compare the operands as two's-complement signed numbers.
- R7: In class 6, only bits 31:0 of each operand take part in the compare. Bits 63:32 have no effect on `out_taken`.
- R8: Code 0x0 in class 5 is always taken.
- R9: `out_next_pc` is `pc + 1 + sign_extend(offset)` when the branch is taken and `pc + 1` otherwise, wrapping modulo 2^PC_W.
- R10: Code 0x8 (class 5 or 6) raises `out_call`. Code 0x9 in class 5 raises `out_exit`. In both cases `out_taken` is 0.
- R11: `out_illegal` is 1, with `out_taken`, `out_call` and `out_exit` at 0, in any of these cases: the class is neither 5 nor 6; the code is 0xe or 0xf; or the instruction is class 6 with code 0x0 or 0x9.
- R12: At most one of `out_taken`, `out_call`, `out_exit`, `out_illegal` is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present on the inputs this cycle |
| opcode | input | 8 | Condition code [7:4], operand select [3], class [2:0] |
| dst_val | input | 64 | First compare operand |
| src_val | input | 64 | Register choice for the second operand |
| imm | input | 32 | Immediate choice for the second operand |
| offset | input | 16 | Signed branch distance in instruction slots |
| pc | input | PC_W | Slot address of this instruction |
| out_valid | output | 1 | Result of the previous cycle's instruction |
| out_taken | output | 1 | Branch taken |
| out_next_pc | output | PC_W | Address of the next instruction |
| out_call | output | 1 | Function call code seen |
| out_exit | output | 1 | Return code seen |
| out_illegal | output | 1 | Encoding rejected |

## Verification
All results come from a single register stage. Every output for an instruction driven before a rising edge is therefore due right after that edge, and in no other cycle. The bench changes inputs on the falling edge and reads the outputs on the following falling edge, which is half a period after the capturing edge. It never samples in the cycle the inputs are applied. One idle cycle with `in_valid` low confirms that the flags drop in the next cycle and do not hold their old values.

// File: rtl/br_pkg.sv
package br_pkg;

    localparam int unsigned OFF_W = 16;
    localparam int unsigned IMM_W = 32;
    localparam logic [2:0] CLS_WIDE   = 3'd5;
    localparam logic [2:0] CLS_NARROW = 3'd6;
    localparam logic [3:0] CODE_LAST  = 4'hd;

    typedef enum logic [3:0] {
        C_ALWAYS = 4'h0,
        C_EQ     = 4'h1,
        C_UGT    = 4'h2,
        C_UGE    = 4'h3,
        C_BITS   = 4'h4,
        C_NE     = 4'h5,
        C_SGT    = 4'h6,
        C_SGE    = 4'h7,
        C_CALL   = 4'h8,
        C_RET    = 4'h9,
        C_ULT    = 4'ha,
        C_ULE    = 4'hb,
        C_SLT    = 4'hc,
        C_SLE    = 4'hd
    } cond_e;

    typedef struct packed {
        logic       is_jump;
        logic       wide;
        logic       use_reg;
        logic [3:0] code;
    } dec_t;

    typedef struct packed {
        logic eq;
        logic ult;
        logic slt;
        logic nz;
    } rel_t;

    typedef struct packed {
        logic taken;
        logic call;
        logic ret;
        logic bad;
    } verdict_t;

    function automatic dec_t decode(input logic [7:0] op);
        dec_t d;
        d.is_jump = (op[2:0] == CLS_WIDE) || (op[2:0] == CLS_NARROW);
        d.wide    = (op[2:0] == CLS_WIDE);
        d.use_reg = op[3];
        d.code    = op[7:4];
        return d;
    endfunction

    function automatic verdict_t judge(input dec_t d, input rel_t r);
        verdict_t v;
        v = '0;
        if (!d.is_jump || (d.code > CODE_LAST) ||
            (!d.wide && (d.code == C_ALWAYS || d.code == C_RET))) begin
            v.bad = 1'b1;
        end else begin
            case (cond_e'(d.code))
                C_ALWAYS: v.taken = 1'b1;
                C_EQ:     v.taken = r.eq;
                C_NE:     v.taken = !r.eq;
                C_BITS:   v.taken = r.nz;
                C_UGT:    v.taken = !r.ult && !r.eq;
                C_UGE:    v.taken = !r.ult;
                C_ULT:    v.taken = r.ult;
                C_ULE:    v.taken = r.ult || r.eq;
                C_SGT:    v.taken = !r.slt && !r.eq;
                C_SGE:    v.taken = !r.slt;
                C_SLT:    v.taken = r.slt;
                C_SLE:    v.taken = r.slt || r.eq;
                C_CALL:   v.call  = 1'b1;
                C_RET:    v.ret   = 1'b1;
                default:  v.bad   = 1'b1;
            endcase
        end
        return v;
    endfunction

endpackage

// File: rtl/br_opsel.sv
module br_opsel
    import br_pkg::*;
#(
    parameter int unsigned XW = 64
) (
    input  dec_t              dec,
    input  logic [XW-1:0]     dst,
    input  logic [XW-1:0]     src,
    input  logic [IMM_W-1:0]  imm,
    output logic [XW-1:0]     op_a,
    output logic [XW-1:0]     op_b
);
    localparam int unsigned EXT_W = XW - IMM_W;

    logic [XW-1:0] imm_ext;
    logic [XW-1:0] b_raw;

    assign imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
    assign b_raw   = dec.use_reg ? src : imm_ext;

    // Narrow compares: both operands sign-extended from bit 31 keeps both
    // unsigned and signed order of the low halves, so one comparator serves.
    assign op_a = dec.wide ? dst   : {{EXT_W{dst[IMM_W-1]}},   dst[IMM_W-1:0]};
    assign op_b = dec.wide ? b_raw : {{EXT_W{b_raw[IMM_W-1]}}, b_raw[IMM_W-1:0]};

endmodule

// File: rtl/br_cond.sv
module br_cond
    import br_pkg::*;
#(
    parameter int unsigned XW = 64
) (
    input  logic [XW-1:0] op_a,
    input  logic [XW-1:0] op_b,
    output rel_t          rel
);
    always_comb begin
        rel.eq  = (op_a == op_b);
        rel.ult = (op_a < op_b);
        rel.slt = ($signed(op_a) < $signed(op_b));
        rel.nz  = |(op_a & op_b);
    end

    // R5
    always_comb begin
        eq_lt_excl_chk: assert (!(rel.eq && (rel.ult || rel.slt)));
    end

endmodule

// File: rtl/br_pcgen.sv
module br_pcgen
    import br_pkg::*;
#(
    parameter int unsigned PC_W = 32
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [OFF_W-1:0] off,
    input  logic             taken,
    output logic [PC_W-1:0]  next_pc
);
    logic [PC_W-1:0] off_ext;
    logic [PC_W-1:0] step;

    generate
        if (PC_W > OFF_W) begin : g_sext
            assign off_ext = {{(PC_W-OFF_W){off[OFF_W-1]}}, off};
        end else begin : g_trunc
            assign off_ext = off[PC_W-1:0];
        end
    endgenerate

    assign step    = taken ? off_ext : '0;
    assign next_pc = pc + PC_W'(1) + step;

endmodule

// File: rtl/branch_resolve.sv
module branch_resolve
    import br_pkg::*;
#(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned PC_W   = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [7:0]        opcode,
    input  logic [DATA_W-1:0] dst_val,
    input  logic [DATA_W-1:0] src_val,
    input  logic [31:0]       imm,
    input  logic [15:0]       offset,
    input  logic [PC_W-1:0]   pc,
    output logic              out_valid,
    output logic              out_taken,
    output logic [PC_W-1:0]   out_next_pc,
    output logic              out_call,
    output logic              out_exit,
    output logic              out_illegal
);
    dec_t              dec;
    rel_t              rel;
    verdict_t          verdict;
    logic [DATA_W-1:0] op_a;
    logic [DATA_W-1:0] op_b;
    logic [PC_W-1:0]   nxt;

    assign dec = decode(opcode);

    br_opsel #(.XW(DATA_W)) u_opsel (
        .dec  (dec),
        .dst  (dst_val),
        .src  (src_val),
        .imm  (imm),
        .op_a (op_a),
        .op_b (op_b)
    );

    br_cond #(.XW(DATA_W)) u_cond (
        .op_a (op_a),
        .op_b (op_b),
        .rel  (rel)
    );

    assign verdict = judge(dec, rel);

    br_pcgen #(.PC_W(PC_W)) u_pcgen (
        .pc      (pc),
        .off     (offset),
        .taken   (verdict.taken),
        .next_pc (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_taken   <= 1'b0;
            out_call    <= 1'b0;
            out_exit    <= 1'b0;
            out_illegal <= 1'b0;
            out_next_pc <= '0;
        end else begin
            out_valid   <= in_valid;
            out_taken   <= in_valid && verdict.taken;
            out_call    <= in_valid && verdict.call;
            out_exit    <= in_valid && verdict.ret;
            out_illegal <= in_valid && verdict.bad;
            out_next_pc <= nxt;
        end
    end

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid && !out_taken && !out_call && !out_exit && !out_illegal);

    // R12
    flag_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({out_taken, out_call, out_exit, out_illegal}));

    // R11
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        out_illegal |-> !out_taken && !out_call && !out_exit);

    // R8
    ja_taken_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && (opcode[7:4] == 4'h0) && (opcode[2:0] == 3'd5) |=> out_taken);

    // R9
    seq_pc_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_taken |-> out_next_pc == $past(pc) + PC_W'(1));

endmodule

// File: tb/branch_resolve_tb.sv
module branch_resolve_tb_top;
    localparam int PC_W = 32;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            in_valid = 1'b0;
    logic [7:0]      opcode = '0;
    logic [63:0]     dst_val = '0;
    logic [63:0]     src_val = '0;
    logic [31:0]     imm = '0;
    logic [15:0]     offset = '0;
    logic [PC_W-1:0] pc = '0;
    logic            out_valid, out_taken, out_call, out_exit, out_illegal;
    logic [PC_W-1:0] out_next_pc;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #5 clk = ~clk;

    branch_resolve #(.DATA_W(64), .PC_W(PC_W)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode),
        .dst_val(dst_val), .src_val(src_val), .imm(imm), .offset(offset),
        .pc(pc), .out_valid(out_valid), .out_taken(out_taken),
        .out_next_pc(out_next_pc), .out_call(out_call), .out_exit(out_exit),
        .out_illegal(out_illegal)
    );

    // Expected flags {taken, call, exit, illegal}, worked from the requirements.
    function automatic logic [3:0] exp_flags(input logic [7:0] op, input logic [63:0] d,
                                             input logic [63:0] s, input logic [31:0] i);
        logic [2:0]  cls = op[2:0];
        logic [3:0]  cc  = op[7:4];
        logic [63:0] b   = op[3] ? s : {{32{i[31]}}, i};
        logic [63:0] ua, ub;
        logic        ugt, ult, sgt, slt, eq, nz, t;
        if (cls != 3'd5 && cls != 3'd6) return 4'b0001;             // R11
        if (cc > 4'hd) return 4'b0001;                               // R11
        if (cls == 3'd6 && (cc == 4'h0 || cc == 4'h9)) return 4'b0001;
        if (cc == 4'h8) return 4'b0100;                              // R10
        if (cc == 4'h9) return 4'b0010;                              // R10
        if (cls == 3'd6) begin                                       // R7
            ua  = {32'b0, d[31:0]};
            ub  = {32'b0, b[31:0]};
            slt = $signed(d[31:0]) < $signed(b[31:0]);
            sgt = $signed(d[31:0]) > $signed(b[31:0]);
        end else begin
            ua  = d;
            ub  = b;
            slt = $signed(d) < $signed(b);
            sgt = $signed(d) > $signed(b);
        end
        eq  = (ua == ub);
        ult = (ua < ub);
        ugt = (ua > ub);
        nz  = (ua & ub) != 0;
        case (cc)
            4'h0: t = 1'b1;
            4'h1: t = eq;
            4'h5: t = !eq;
            4'h4: t = nz;
            4'h2: t = ugt;
            4'h3: t = ugt || eq;
            4'ha: t = ult;
            4'hb: t = ult || eq;
            4'h6: t = sgt;
            4'h7: t = sgt || eq;
            4'hc: t = slt;
            default: t = slt || eq;
        endcase
        return {t, 3'b000};
    endfunction

    function automatic string tag_for(input logic [7:0] op);
        logic [3:0] cc = op[7:4];
        if (op[2:0] != 3'd5 && op[2:0] != 3'd6) return "R11";
        if (cc > 4'hd) return "R11";
        if (op[2:0] == 3'd6 && (cc == 4'h0 || cc == 4'h9)) return "R11";
        if (cc == 4'h8 || cc == 4'h9) return "R10";
        if (cc == 4'h0) return "R8";
        if (cc == 4'h1 || cc == 4'h4 || cc == 4'h5) return "R4";
        if (cc == 4'h2 || cc == 4'h3 || cc == 4'ha || cc == 4'hb) return "R5";
        return "R6";
    endfunction

    // Called at a falling edge; result read at the next falling edge.
    task automatic run_one(input string tag, input logic [7:0] op, input logic [63:0] d,
                           input logic [63:0] s, input logic [31:0] i,
                           input logic [15:0] off, input logic [PC_W-1:0] p);
        logic [3:0]      ef;
        logic [PC_W-1:0] epc;
        in_valid = 1'b1; opcode = op; dst_val = d; src_val = s; imm = i;
        offset = off; pc = p;
        ef  = exp_flags(op, d, s, i);
        epc = p + PC_W'(1) + (ef[3] ? {{(PC_W-16){off[15]}}, off} : '0);
        @(negedge clk);
        checks++;
        if ({out_valid, out_taken, out_call, out_exit, out_illegal} != {1'b1, ef} ||
            out_next_pc != epc) begin
            errors++;
            $display("FAIL %s op=%h: got v=%b flags=%b pc=%h, want v=1 flags=%b pc=%h",
                     tag, op, out_valid, {out_taken, out_call, out_exit, out_illegal},
                     out_next_pc, ef, epc);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got hung run, want completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        in_valid = 1'b1;
        opcode   = 8'h05;
        repeat (3) @(negedge clk);
        // R1: outputs held low during reset even with an instruction present
        checks++;
        if ({out_valid, out_taken, out_call, out_exit, out_illegal} != 5'b0) begin
            errors++;
            $display("FAIL R1: got %b want 00000",
                     {out_valid, out_taken, out_call, out_exit, out_illegal});
        end
        rst = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);

        // R8: unconditional, negative offset
        run_one("R8", 8'h05, 64'd1, 64'd2, 32'd0, 16'hfffe, 32'h100);
        // R2: idle cycle clears all outputs
        in_valid = 1'b0;
        @(negedge clk);
        checks++;
        if ({out_valid, out_taken, out_call, out_exit, out_illegal} != 5'b0) begin
            errors++;
            $display("FAIL R2: got %b want 00000",
                     {out_valid, out_taken, out_call, out_exit, out_illegal});
        end
        // R4: equality on register and bit test
        run_one("R4", 8'h1d, 64'h1234_5678_9abc_def0, 64'h1234_5678_9abc_def0, 0, 16'd10, 32'd7);
        run_one("R4", 8'h45, 64'h8000_0000_0000_0000, 64'd0, 32'h8000_0000, 16'd3, 32'd7);
        // R3: immediate -1 sign-extended in wide class equals all ones
        run_one("R3", 8'h15, 64'hffff_ffff_ffff_ffff, 64'd0, 32'hffff_ffff, 16'd4, 32'd20);
        // R3: narrow class, immediate compared to low half only
        run_one("R3", 8'h16, 64'h0000_0001_ffff_ffff, 64'd0, 32'hffff_ffff, 16'd4, 32'd20);
        // R5: unsigned greater with top bit set
        run_one("R5", 8'h2d, 64'h8000_0000_0000_0000, 64'd1, 0, 16'd8, 32'd30);
        // R6: same operands, signed less
        run_one("R6", 8'hcd, 64'h8000_0000_0000_0000, 64'd1, 0, 16'd8, 32'd30);
        // R7: upper halves differ, low halves equal in narrow class
        run_one("R7", 8'h1e, 64'haaaa_aaaa_0000_0042, 64'h5555_5555_0000_0042, 0, 16'd2, 32'd40);
        run_one("R7", 8'h5e, 64'haaaa_aaaa_0000_0042, 64'h5555_5555_0000_0042, 0, 16'd2, 32'd40);
        // R10: call in both classes, return in wide class
        run_one("R10", 8'h85, 64'd0, 64'd0, 32'd9, 16'd5, 32'd50);
        run_one("R10", 8'h86, 64'd0, 64'd0, 32'd9, 16'd5, 32'd50);
        run_one("R10", 8'h95, 64'd0, 64'd0, 32'd0, 16'd5, 32'd50);
        // R11: narrow unconditional and return, high codes, foreign class
        run_one("R11", 8'h06, 64'd0, 64'd0, 0, 16'd5, 32'd60);
        run_one("R11", 8'h96, 64'd0, 64'd0, 0, 16'd5, 32'd60);
        run_one("R11", 8'he5, 64'd0, 64'd0, 0, 16'd5, 32'd60);
        run_one("R11", 8'hf6, 64'd0, 64'd0, 0, 16'd5, 32'd60);
        run_one("R11", 8'h17, 64'd0, 64'd0, 0, 16'd5, 32'd60);
        // R9: wrap at top of PC range, taken forward
        run_one("R9", 8'h05, 64'd0, 64'd0, 0, 16'd2, 32'hffff_fffe);
        run_one("R9", 8'h55, 64'd0, 64'd0, 0, 16'h8000, 32'hffff_ffff);

        // R12 and all compare requirements under random stimulus
        for (int n = 0; n < 3000; n++) begin
            logic [63:0] d = {$urandom, $urandom};
            logic [63:0] s;
            logic [31:0] i = $urandom;
            logic [7:0]  op;
            int unsigned mode = $urandom % 5;
            int unsigned pick = $urandom % 8;
            case (mode)
                0: s = d;
                1: s = {$urandom, d[31:0]};
                2: s = d + 64'($urandom % 3) - 64'd1;
                3: s = {d[63:32], $urandom};
                default: s = {$urandom, $urandom};
            endcase
            if ($urandom % 4 == 0) i = s[31:0];
            op[7:4] = 4'($urandom);
            op[3]   = 1'($urandom);
            op[2:0] = (pick < 3) ? 3'd5 : (pick < 7) ? 3'd6 : 3'($urandom);
            run_one(tag_for(op), op, d, s, i, 16'($urandom), 32'($urandom));
        end
        finish_run();
    end
endmodule